// File: doc/BRIEF.md
# I2C Start Reservation Controller

This block sits inside an I2C master and decides what to do when software asks for a start condition. When the bus is free, or when this device already owns it, a start is issued at once. When another master holds the bus, the request is parked as a reservation. The start then fires by itself at the next stop condition seen on the bus.

Every start the block generates raises a wait flag. A later write to the data register clears that flag and launches the address transfer. Software finds out which path its request took by reading a master-status flag. That flag changes exactly a fixed number of clocks after the request and holds its value in between.

The block tracks bus occupancy from the start and stop detectors. It also tracks whether this device still owns the bus, which it stops doing after losing arbitration or after an extension code while slave operation is off. A pending reservation is cancelled if this device is addressed as a slave.

Top module: `i2c_start_sched`

## Requirements
- R1: `bus_busy` is 0 after reset. A `start_seen` pulse sets it and a `stop_seen` pulse clears it. When both arrive in the same cycle, the stop wins.
- R2: A `start_req` seen while `bus_busy` is 0, or while this device owns the bus, produces a one-cycle `gen_start` pulse on the next clock edge and makes the device the bus owner.
- R3: A `start_req` seen while the bus is busy and not owned, with `resv_dis`=0 and `stop_irq_en`=1, drives no `gen_start` and sets `pending` on the next edge.
- R4: In the busy, not-owned case, a `start_req` with `resv_dis`=1 or `stop_irq_en`=0 is dropped. Neither `gen_start` nor `pending` rises.
- R5: A `stop_seen` while `pending` is 1 (with no cancel or stop request in that cycle) gives a `gen_start` pulse on the next edge, clears `pending` and sets `wait_hold`. Every generated start sets `wait_hold`.
- R6: A `data_wr` while `wait_hold` is 1 gives a one-cycle `xfer_go` pulse on the next edge and clears `wait_hold`. A `data_wr` while `wait_hold` is 0 has no effect.
- R7: The device stops owning the bus on `stop_seen`, on `arb_lost` without `slave_hit`, or on `ext_code` with `slave_dis`=1. A later `start_req` on the still-busy bus is then reserved rather than issued. `ext_code` with `slave_dis`=0 leaves ownership unchanged.
- R8: `mst_flag` changes only on the WAIT_CLKS-th clock edge after a `start_req`. It becomes 1 if that request took the immediate path and 0 otherwise, and holds its value at all other times.
- R9: A `slave_hit` while `pending` is 1 clears `pending` and sets `cancelled`. `cancelled` is cleared by the next `start_req`.
- R10: `stop_req` clears `pending`. `soft_rst` returns every output to its reset value of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous block reset |
| start_req | input | 1 | Software start request (one-cycle pulse) |
| stop_req | input | 1 | Software stop request (pulse) |
| resv_dis | input | 1 | 1 disables reservations |
| stop_irq_en | input | 1 | Stop-detect interrupt enable; needed for reservations |
| data_wr | input | 1 | Data register write strobe |
| start_seen | input | 1 | Start condition detected on the bus |
| stop_seen | input | 1 | Stop condition detected on the bus |
| arb_lost | input | 1 | Arbitration lost |
| slave_hit | input | 1 | This device addressed as slave |
| ext_code | input | 1 | Extension code received |
| slave_dis | input | 1 | Slave operation disabled |
| gen_start | output | 1 | Pulse: drive a start condition |
| xfer_go | output | 1 | Pulse: begin address transfer |
| wait_hold | output | 1 | Wait state after a generated start |
| pending | output | 1 | Reservation outstanding |
| cancelled | output | 1 | Last reservation was cancelled |
| bus_busy | output | 1 | Bus occupied |
| mst_flag | output | 1 | Master-status result of the last request |

## Verification
The hardest state to reach from the ports is a reservation made after this device has dropped out of ownership while the bus is still busy. That case needs the device to issue a start and see its own start on the bus, then lose ownership without any stop. The bench builds this by pulsing `start_seen` after an immediate start, then `arb_lost` (or `ext_code` with `slave_dis`), and then asks again. Each time it counts edges to sample `mst_flag` one edge before and exactly at the end of the wait window, for both the issued and the reserved outcome.

// File: rtl/i2c_rsv_pkg.sv
`timescale 1ns/1ps
package i2c_rsv_pkg;

  typedef enum logic [1:0] {
    PATH_DROP    = 2'd0,
    PATH_START   = 2'd1,
    PATH_RESERVE = 2'd2
  } path_e;

  // Outcome of a start request given the bus view and the enables.
  function automatic path_e choose_path(input logic busy, input logic owns,
                                        input logic resv_dis, input logic irq_en);
    if (!busy || owns) return PATH_START;
    if (!resv_dis && irq_en) return PATH_RESERVE;
    return PATH_DROP;
  endfunction

endpackage

// File: rtl/i2c_rsv_bus_track.sv
`timescale 1ns/1ps
module i2c_rsv_bus_track (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic start_seen,
  input  logic stop_seen,
  input  logic arb_lost,
  input  logic slave_hit,
  input  logic ext_code,
  input  logic slave_dis,
  input  logic start_evt,
  output logic bus_busy,
  output logic owns
);

  logic dropout;
  assign dropout = (arb_lost && !slave_hit) || (ext_code && slave_dis);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_busy <= 1'b0;
      owns     <= 1'b0;
    end else if (soft_rst) begin
      bus_busy <= 1'b0;
      owns     <= 1'b0;
    end else begin
      if (stop_seen)       bus_busy <= 1'b0;
      else if (start_seen) bus_busy <= 1'b1;
      if (start_evt)                  owns <= 1'b1;
      else if (stop_seen || dropout)  owns <= 1'b0;
    end
  end

  // R1: a stop always frees the bus
  a_r1_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !bus_busy);

  // R7: losing arbitration without being addressed ends ownership
  a_r7_dropout: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !slave_hit && !start_evt) |=> !owns);

endmodule

// File: rtl/i2c_rsv_core.sv
`timescale 1ns/1ps
module i2c_rsv_core
  import i2c_rsv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_rst,
  input  logic  start_req,
  input  logic  stop_req,
  input  logic  resv_dis,
  input  logic  stop_irq_en,
  input  logic  data_wr,
  input  logic  stop_seen,
  input  logic  slave_hit,
  input  logic  bus_busy,
  input  logic  owns,
  output logic  start_evt,
  output path_e path,
  output logic  gen_start,
  output logic  wait_hold,
  output logic  xfer_go,
  output logic  pending,
  output logic  cancelled
);

  logic issue_imm, issue_rsv, cancel_evt, reserve_evt;

  assign path        = choose_path(bus_busy, owns, resv_dis, stop_irq_en);
  assign issue_imm   = start_req && (path == PATH_START);
  assign reserve_evt = start_req && (path == PATH_RESERVE);
  assign cancel_evt  = pending && slave_hit && !stop_req;
  assign issue_rsv   = pending && stop_seen && !cancel_evt && !stop_req;
  assign start_evt   = (issue_imm || issue_rsv) && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_start <= 1'b0;
      wait_hold <= 1'b0;
      xfer_go   <= 1'b0;
      pending   <= 1'b0;
      cancelled <= 1'b0;
    end else if (soft_rst) begin
      gen_start <= 1'b0;
      wait_hold <= 1'b0;
      xfer_go   <= 1'b0;
      pending   <= 1'b0;
      cancelled <= 1'b0;
    end else begin
      gen_start <= start_evt;
      xfer_go   <= data_wr && wait_hold;
      if (start_evt)    wait_hold <= 1'b1;
      else if (data_wr) wait_hold <= 1'b0;
      if (stop_req || cancel_evt || issue_rsv) pending <= 1'b0;
      else if (reserve_evt)                    pending <= 1'b1;
      if (cancel_evt)     cancelled <= 1'b1;
      else if (start_req) cancelled <= 1'b0;
    end
  end

  // R2: request on a free bus starts at the next edge
  a_r2_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !bus_busy && !soft_rst) |=> (gen_start && wait_hold));

  // R4: a reservation only appears after an enabled request
  a_r4_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(start_req && !resv_dis && stop_irq_en));

  // R5: a pending request fires on the stop
  a_r5_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && stop_seen && !slave_hit && !stop_req && !soft_rst)
      |=> (gen_start && wait_hold && !pending));

  // R6: the transfer launch is a single pulse
  a_r6_xfer_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |=> !xfer_go);

  // R9: addressed as slave cancels the reservation
  a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && slave_hit && !stop_req && !soft_rst) |=> (cancelled && !pending));

endmodule

// File: rtl/i2c_rsv_status.sv
`timescale 1ns/1ps
module i2c_rsv_status #(
  parameter int WAIT_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic start_req,
  input  logic issued,
  output logic mst_flag
);

  localparam int CW = $clog2(WAIT_CLKS + 1);

  logic [CW-1:0] cnt;
  logic          verdict;
  logic          expire_evt;

  function automatic logic [CW-1:0] tick(input logic [CW-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  assign expire_evt = (cnt == CW'(1)) && !start_req && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      verdict  <= 1'b0;
      mst_flag <= 1'b0;
    end else if (soft_rst) begin
      cnt      <= '0;
      verdict  <= 1'b0;
      mst_flag <= 1'b0;
    end else if (start_req) begin
      cnt     <= CW'(WAIT_CLKS);
      verdict <= issued;
    end else begin
      cnt <= tick(cnt);
      if (expire_evt) mst_flag <= verdict;
    end
  end

  // R8: the flag holds outside the end of the window
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!expire_evt && !soft_rst) |=> $stable(mst_flag));

endmodule

// File: rtl/i2c_start_sched.sv
`timescale 1ns/1ps
module i2c_start_sched
  import i2c_rsv_pkg::*;
#(
  parameter int WAIT_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic start_req,
  input  logic stop_req,
  input  logic resv_dis,
  input  logic stop_irq_en,
  input  logic data_wr,
  input  logic start_seen,
  input  logic stop_seen,
  input  logic arb_lost,
  input  logic slave_hit,
  input  logic ext_code,
  input  logic slave_dis,
  output logic gen_start,
  output logic xfer_go,
  output logic wait_hold,
  output logic pending,
  output logic cancelled,
  output logic bus_busy,
  output logic mst_flag
);

  logic  start_evt;
  logic  owns;
  path_e path;

  i2c_rsv_bus_track u_track (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .start_seen(start_seen), .stop_seen(stop_seen),
    .arb_lost(arb_lost), .slave_hit(slave_hit),
    .ext_code(ext_code), .slave_dis(slave_dis),
    .start_evt(start_evt), .bus_busy(bus_busy), .owns(owns)
  );

  i2c_rsv_core u_core (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .start_req(start_req), .stop_req(stop_req),
    .resv_dis(resv_dis), .stop_irq_en(stop_irq_en),
    .data_wr(data_wr), .stop_seen(stop_seen), .slave_hit(slave_hit),
    .bus_busy(bus_busy), .owns(owns),
    .start_evt(start_evt), .path(path),
    .gen_start(gen_start), .wait_hold(wait_hold), .xfer_go(xfer_go),
    .pending(pending), .cancelled(cancelled)
  );

  i2c_rsv_status #(.WAIT_CLKS(WAIT_CLKS)) u_status (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .start_req(start_req), .issued(path == PATH_START),
    .mst_flag(mst_flag)
  );

endmodule

// File: tb/i2c_start_sched_test.sv
`timescale 1ns/1ps
module i2c_start_sched_test;

  localparam int WAIT = 8;
  localparam int NV   = 19;
  // bits: [11]start_seen [10]stop_seen [9]start_req [8]resv_dis [7]stop_irq_en
  //       [6]data_wr [5]slave_hit | expect [4]busy [3]gen [2]pend [1]wait [0]xfer
  localparam logic [11:0] VECS [0:NV-1] = '{
    12'b0010100_01010, 12'b1000100_10010, 12'b0000110_10001, 12'b0000100_10000,
    12'b0100100_00000, 12'b1000100_10000, 12'b0010100_10100, 12'b0000110_10100,
    12'b0100100_01010, 12'b0000100_00010, 12'b0000110_00001, 12'b1000100_10000,
    12'b0100100_00000, 12'b1000100_10000, 12'b0011100_10000, 12'b0010000_10000,
    12'b0010100_10100, 12'b0000101_10000, 12'b0100100_00000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, start_req = 0, stop_req = 0, resv_dis = 0, stop_irq_en = 0;
  logic data_wr = 0, start_seen = 0, stop_seen = 0, arb_lost = 0, slave_hit = 0;
  logic ext_code = 0, slave_dis = 0;
  logic gen_start, xfer_go, wait_hold, pending, cancelled, bus_busy, mst_flag;
  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  i2c_start_sched #(.WAIT_CLKS(WAIT)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start_req(start_req),
    .stop_req(stop_req), .resv_dis(resv_dis), .stop_irq_en(stop_irq_en),
    .data_wr(data_wr), .start_seen(start_seen), .stop_seen(stop_seen),
    .arb_lost(arb_lost), .slave_hit(slave_hit), .ext_code(ext_code),
    .slave_dis(slave_dis), .gen_start(gen_start), .xfer_go(xfer_go),
    .wait_hold(wait_hold), .pending(pending), .cancelled(cancelled),
    .bus_busy(bus_busy), .mst_flag(mst_flag)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic clear_pulses();
    soft_rst = 0; start_req = 0; stop_req = 0; data_wr = 0; start_seen = 0;
    stop_seen = 0; arb_lost = 0; slave_hit = 0; ext_code = 0;
  endtask

  task automatic do_soft_rst();
    soft_rst = 1; step(); clear_pulses();
  endtask

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    check("R1 R10 reset state", {bus_busy, gen_start, pending, wait_hold, xfer_go, cancelled, mst_flag}, 7'b0);

    // table walk: one vector per cycle
    for (int i = 0; i < NV; i++) begin
      {start_seen, stop_seen, start_req, resv_dis, stop_irq_en, data_wr, slave_hit} = VECS[i][11:5];
      step();
      check($sformatf("table row %0d (R1 R2 R3 R4 R5 R6 R9)", i),
            {2'b00, bus_busy, gen_start, pending, wait_hold, xfer_go}, {2'b00, VECS[i][4:0]});
    end
    clear_pulses();
    stop_irq_en = 1; resv_dis = 0;

    // R10: soft reset clears everything (cancelled was 1)
    do_soft_rst();
    check("R10 soft reset", {bus_busy, gen_start, pending, wait_hold, xfer_go, cancelled, mst_flag}, 7'b0);

    // R1: start and stop together leave the bus free
    start_seen = 1; step(); clear_pulses();
    start_seen = 1; stop_seen = 1; step(); clear_pulses();
    check("R1 stop wins", {6'b0, bus_busy}, 7'b0);

    // R8: immediate path, flag reaches 1 exactly WAIT edges later
    start_req = 1; step(); clear_pulses();
    check("R2 immediate start", {6'b0, gen_start}, 7'd1);
    for (int k = 0; k < WAIT - 1; k++) step();
    check("R8 flag before window end", {6'b0, mst_flag}, 7'd0);
    step();
    check("R8 flag at window end (issued)", {6'b0, mst_flag}, 7'd1);

    // R7: own start seen, then arbitration lost -> next request reserved
    start_seen = 1; step(); clear_pulses();
    arb_lost = 1; step(); clear_pulses();
    start_req = 1; step(); clear_pulses();
    check("R7 R3 reserved after arbitration loss", {5'b0, gen_start, pending}, 7'b01);
    for (int k = 0; k < WAIT - 1; k++) step();
    check("R8 flag holds during window", {6'b0, mst_flag}, 7'd1);
    step();
    check("R8 flag at window end (reserved)", {6'b0, mst_flag}, 7'd0);

    // R10: stop request drops the reservation; a later stop fires nothing
    stop_req = 1; step(); clear_pulses();
    check("R10 stop request clears pending", {6'b0, pending}, 7'd0);
    stop_seen = 1; step(); clear_pulses();
    check("R10 no fire after clear", {5'b0, gen_start, bus_busy}, 7'b0);

    // R9: cancel on slave address, cleared by next request
    start_seen = 1; step(); clear_pulses();
    start_req = 1; step(); clear_pulses();
    slave_hit = 1; step(); clear_pulses();
    check("R9 cancel sets flag", {5'b0, pending, cancelled}, 7'b01);
    start_req = 1; step(); clear_pulses();
    check("R9 next request clears cancel", {5'b0, pending, cancelled}, 7'b10);

    // R7: extension code with slave disabled ends ownership
    do_soft_rst();
    start_req = 1; step(); clear_pulses();
    start_seen = 1; step(); clear_pulses();
    slave_dis = 1; ext_code = 1; step(); clear_pulses(); slave_dis = 0;
    start_req = 1; step(); clear_pulses();
    check("R7 extension code drop-out", {5'b0, gen_start, pending}, 7'b01);

    // R7: extension code with slave enabled keeps ownership
    do_soft_rst();
    start_req = 1; step(); clear_pulses();
    start_seen = 1; step(); clear_pulses();
    ext_code = 1; step(); clear_pulses();
    start_req = 1; step(); clear_pulses();
    check("R7 ownership kept", {5'b0, gen_start, pending}, 7'b10);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule